// File: doc/BRIEF.md
# Serial Output Formatter with Burst Bit Clock

This block takes one pair of wide parallel left and right samples per output word and sends them out as two serial streams at the same time, MSB first, in two's complement. It also makes three timing outputs, all derived from its own clock: a bit clock that pulses only while data bits are on the lines, a word clock that splits each word period into two equal halves, and a settle strobe that marks the quiet part of the word. Each bit slot lasts two clock cycles: the bit clock is low in the first cycle and high in the second. Data and word clock therefore change only on the falling edge of the bit clock.

The output length can be 24, 22, 20 or 18 bits. Each 25-bit sample is rounded to that length and saturated if it overflows. The word period is 24 slots in the fast-rate mode and 32 slots in the slow-rate mode. Samples and configuration are captured together at each falling edge of the word clock. The burst that follows carries that captured pair. The burst is placed so that its last bit lands in a fixed slot.

Top module: `serout_fmt`

## Requirements
- R1: `len_code` selects the word length: 0 gives 24 bits, 1 gives 22, 2 gives 20 and 3 gives 18. Each burst has exactly that many bit clock pulses.
- R2: A bit slot is two clock cycles, with the bit clock low in the first and high in the second, so each bit clock pulse lasts one cycle. A word lasts 24 slots when `rate_fast` is 1 and 32 slots when it is 0.
- R3: The word clock is high for the first half of each word (12 or 16 slots) and low for the second half. It changes only while the bit clock is low.
- R4: The settle strobe rises one slot after the word clock falls and stays high for 10 slots in the fast-rate mode or 14 slots in the slow-rate mode. It is never high together with the word clock.
- R5: Both data lines carry their bits in the same slots, MSB first. A data line changes only while the bit clock is low.
- R6: The slot of the last bit is fixed. In the slow-rate mode it is slot 31 for every length. In the fast-rate mode it is slot 23 for 18, 20 and 22 bits. For 24 bits it is slot 22, so that burst starts one slot earlier, in slot 23 of the preceding word. Slots are counted from 0 at the rise of the word clock.
- R7: Rounding to n bits adds one half of the output LSB and then shifts right arithmetically by 25−n.
- R8: A rounded value above the largest positive n-bit number becomes that largest number.
- R9: The samples and the configuration are captured on the cycle the word clock falls. Every burst carries the pair captured at the most recent fall before it began.
- R10: While `rst_n` is low, all five outputs are low. The first slot after release is slot 0 of a new word, with the word clock high.
- R11: Outside a burst both data lines are low. A data line that is high while the bit clock is low is followed by a bit clock pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock, two cycles per bit slot |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_fast | input | 1 | 1: 24-slot word; 0: 32-slot word |
| len_code | input | 2 | Output word length select (R1) |
| smp_l | input | 25 | Left sample, two's complement |
| smp_r | input | 25 | Right sample, two's complement |
| bck_o | output | 1 | Burst bit clock |
| wck_o | output | 1 | Word clock |
| dg_o | output | 1 | Settle strobe |
| dout_l | output | 1 | Left serial data |
| dout_r | output | 1 | Right serial data |

## Verification
A slot counter off by one moves the word clock, the strobe and the last-bit slot within one word. The bench measures each of these against the rise of the word clock, so the error shows within one word. A wrong burst count or a wrong load slot shows as a wrong number of pulses or as shifted bits, in the first burst after a configuration has settled. Errors in rounding or saturation show only for certain sample values. The stimulus therefore mixes full-scale, most-negative, minus-one and random samples for every mode and length, and each error appears in the first burst that carries such a value.

// File: rtl/serout_pkg.sv
// Shared types for the serial output formatter.
// Assumes the length select is a two-bit code in steps of a fixed size.
package serout_pkg;
    localparam int LEN_CODE_W = 2;

    typedef struct packed {
        logic                  rate_fast;
        logic [LEN_CODE_W-1:0] len_code;
    } serout_cfg_t;
endpackage

// File: rtl/serout_timer.sv
// Slot timer: a two-phase bit slot and a slot index that wraps at last_slot.
// Assumes last_slot changes only while the slot index is below the new limit.
// In reset it parks on the last phase of the last slot, so that every
// decoded output stays low and slot 0 starts on the first cycle after release.
module serout_timer #(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic [SLOT_W-1:0] rst_last,
    output logic              phase_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [SLOT_W-1:0] slot_nxt_o
);
    // Next slot index: it advances at the end of the high phase.
    always_comb begin
        if (!phase_o)
            slot_nxt_o = slot_o;
        else if (slot_o == last_slot)
            slot_nxt_o = '0;
        else
            slot_nxt_o = slot_o + 1'b1;
    end

    // Phase and slot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= 1'b1;
            slot_o  <= rst_last;
        end else begin
            phase_o <= ~phase_o;
            slot_o  <= slot_nxt_o;
        end
    end
endmodule

// File: rtl/serout_burst.sv
// Burst controller: finds the start slot of each burst from the rate and the
// length, counts the bits still to go and produces the load and shift strobes.
// Assumes nbits is one of the valid lengths and OUT_W equals SLOTS_FAST.
module serout_burst #(
    parameter int OUT_W      = 24,
    parameter int SLOTS_FAST = 24,
    parameter int SLOTS_SLOW = 32,
    parameter int SLOT_W     = 5,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic [SLOT_W-1:0] slot_nxt,
    input  logic              rate_fast,
    input  logic [CNT_W-1:0]  nbits,
    output logic              active_o,
    output logic              load_o,
    output logic              shift_o
);
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] start;

    // Start slot: the last bit lands in a fixed slot. A full-width word in the fast mode starts one slot early.
    always_comb begin
        if (rate_fast) begin
            if (int'(nbits) == OUT_W)
                start = SLOT_W'(SLOTS_FAST - 1);
            else
                start = SLOT_W'(SLOTS_FAST - int'(nbits));
        end else begin
            start = SLOT_W'(SLOTS_SLOW - int'(nbits));
        end
    end

    // Strobes: load when the next slot is the start slot, shift at the end of each bit slot.
    always_comb begin
        load_o   = phase && (slot_nxt == start);
        active_o = (cnt != '0);
        shift_o  = phase && active_o && !load_o;
    end

    // Count of bits still to send.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_o)
            cnt <= nbits;
        else if (phase && active_o)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/serout_round.sv
// Rounds a wide two's complement sample to one of NLEN output lengths,
// saturating on positive overflow, and left-justifies it in OUT_W bits.
// Assumes IN_W > OUT_W, so every length drops at least one bit.
module serout_round #(
    parameter int IN_W     = 25,
    parameter int OUT_W    = 24,
    parameter int LEN_STEP = 2,
    parameter int CODE_W   = 2
) (
    input  logic [IN_W-1:0]   x,
    input  logic [CODE_W-1:0] len_code,
    output logic [OUT_W-1:0]  y
);
    localparam int NLEN = 2 ** CODE_W;

    logic [OUT_W-1:0] cand [NLEN];

    for (genvar k = 0; k < NLEN; k++) begin : g_len
        localparam int N  = OUT_W - LEN_STEP * k;
        localparam int SH = IN_W - N;
        logic [N:0]   r;
        logic [N-1:0] v;
        // Round half up: keep the top bits and add the first dropped bit.
        always_comb begin
            r = {x[IN_W-1], x[IN_W-1:SH]} + (N+1)'(x[SH-1]);
            if (r[N] != r[N-1])
                v = {1'b0, {(N-1){1'b1}}};
            else
                v = r[N-1:0];
            cand[k] = OUT_W'(v) << (OUT_W - N);
        end
    end

    // Pick the candidate for the selected length.
    always_comb y = cand[len_code];
endmodule

// File: rtl/serout_shift.sv
// One channel's output shift register: loaded with a left-justified word and
// shifted left once per bit slot. Assumes load and shift never coincide.
module serout_shift #(
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [OUT_W-1:0] din,
    output logic             msb_o
);
    logic [OUT_W-1:0] sh;

    // Load or shift the serial word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else if (load)
            sh <= din;
        else if (shift)
            sh <= {sh[OUT_W-2:0], 1'b0};
    end

    always_comb msb_o = sh[OUT_W-1];
endmodule

// File: rtl/serout_fmt.sv
// Serial output formatter top. Captures a left/right sample pair and the
// configuration at each word clock fall, rounds both samples to the selected
// length and sends them in a gated bit clock burst whose last bit sits in a
// fixed slot. It also makes the word clock and the settle strobe.
// Assumes the inputs stay stable around the word clock fall.
module serout_fmt #(
    parameter int IN_W       = 25,
    parameter int OUT_W      = 24,
    parameter int LEN_STEP   = 2,
    parameter int SLOTS_FAST = 24,
    parameter int SLOTS_SLOW = 32,
    parameter int STRB_FAST  = 10,
    parameter int STRB_SLOW  = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rate_fast,
    input  logic [1:0]      len_code,
    input  logic [IN_W-1:0] smp_l,
    input  logic [IN_W-1:0] smp_r,
    output logic            bck_o,
    output logic            wck_o,
    output logic            dg_o,
    output logic            dout_l,
    output logic            dout_r
);
    import serout_pkg::*;

    localparam int NCH    = 2;
    localparam int SLOT_W = $clog2(SLOTS_SLOW);
    localparam int CNT_W  = $clog2(OUT_W + 1);
    localparam logic [SLOT_W-1:0] LAST_F  = SLOT_W'(SLOTS_FAST - 1);
    localparam logic [SLOT_W-1:0] LAST_S  = SLOT_W'(SLOTS_SLOW - 1);
    localparam logic [SLOT_W-1:0] HALF_F  = SLOT_W'(SLOTS_FAST / 2);
    localparam logic [SLOT_W-1:0] HALF_S  = SLOT_W'(SLOTS_SLOW / 2);
    localparam logic [SLOT_W-1:0] DGLO_F  = SLOT_W'(SLOTS_FAST / 2 + 1);
    localparam logic [SLOT_W-1:0] DGLO_S  = SLOT_W'(SLOTS_SLOW / 2 + 1);
    localparam logic [SLOT_W-1:0] DGHI_F  = SLOT_W'(SLOTS_FAST / 2 + 1 + STRB_FAST);
    localparam logic [SLOT_W-1:0] DGHI_S  = SLOT_W'(SLOTS_SLOW / 2 + 1 + STRB_SLOW);

    serout_cfg_t       cfg_in, cfg_q;
    logic              phase;
    logic [SLOT_W-1:0] slot, slot_nxt, last_slot, rst_last, half, dg_lo, dg_hi;
    logic [CNT_W-1:0]  nbits;
    logic              latch_evt, active, load, shift;
    logic [IN_W-1:0]   smp [NCH];
    logic [NCH-1:0]    msb;

    // Per-mode slot limits decoded from the captured configuration.
    always_comb begin
        cfg_in    = '{rate_fast: rate_fast, len_code: len_code};
        last_slot = cfg_q.rate_fast ? LAST_F : LAST_S;
        half      = cfg_q.rate_fast ? HALF_F : HALF_S;
        dg_lo     = cfg_q.rate_fast ? DGLO_F : DGLO_S;
        dg_hi     = cfg_q.rate_fast ? DGHI_F : DGHI_S;
        rst_last  = rate_fast ? LAST_F : LAST_S;
        nbits     = CNT_W'(OUT_W - LEN_STEP * int'(cfg_q.len_code));
        latch_evt = phase && (slot == half - 1'b1);
    end

    // Configuration capture at the word clock fall; it follows the inputs while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= cfg_in;
        else if (latch_evt)
            cfg_q <= cfg_in;
    end

    serout_timer #(.SLOT_W(SLOT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_slot  (last_slot),
        .rst_last   (rst_last),
        .phase_o    (phase),
        .slot_o     (slot),
        .slot_nxt_o (slot_nxt)
    );

    serout_burst #(
        .OUT_W      (OUT_W),
        .SLOTS_FAST (SLOTS_FAST),
        .SLOTS_SLOW (SLOTS_SLOW),
        .SLOT_W     (SLOT_W),
        .CNT_W      (CNT_W)
    ) i_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .slot_nxt  (slot_nxt),
        .rate_fast (cfg_q.rate_fast),
        .nbits     (nbits),
        .active_o  (active),
        .load_o    (load),
        .shift_o   (shift)
    );

    always_comb begin
        smp[0] = smp_l;
        smp[1] = smp_r;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [OUT_W-1:0] rnd, hold;

        serout_round #(
            .IN_W     (IN_W),
            .OUT_W    (OUT_W),
            .LEN_STEP (LEN_STEP),
            .CODE_W   (LEN_CODE_W)
        ) i_round (
            .x        (smp[ch]),
            .len_code (len_code),
            .y        (rnd)
        );

        // Holding register: the rounded word captured at the word clock fall.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold <= '0;
            else if (latch_evt)
                hold <= rnd;
        end

        serout_shift #(.OUT_W(OUT_W)) i_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .shift (shift),
            .din   (hold),
            .msb_o (msb[ch])
        );
    end

    // Output decode from registered state.
    always_comb begin
        bck_o  = phase && active;
        wck_o  = (slot < half);
        dg_o   = (slot >= dg_lo) && (slot < dg_hi);
        dout_l = active && msb[0];
        dout_r = active && msb[1];
    end
endmodule

// File: rtl/serout_fmt_chk.sv
// Port-level protocol checker for serout_fmt, attached with bind.
module serout_fmt_chk (
    input logic clk,
    input logic rst_n,
    input logic bck,
    input logic wck,
    input logic dg,
    input logic dl,
    input logic dr
);
    // R10: a reset cycle leaves every output low.
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!bck && !wck && !dg && !dl && !dr));

    // R2: each bit clock pulse lasts one cycle.
    p_bck_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bck |=> !bck);

    // R3: the word clock moves only while the bit clock is low.
    p_wck_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wck) |-> !bck);

    // R4: the strobe and the word clock are never high together.
    p_dg_not_wck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dg |-> !wck);

    // R5: the left data line moves only while the bit clock is low.
    p_left_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dl) |-> !bck);

    // R5: the right data line moves only while the bit clock is low.
    p_right_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dr) |-> !bck);

    // R11: a high data bit seen with the bit clock low belongs to a slot whose pulse follows.
    p_data_in_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((dl || dr) && !bck) |=> bck);
endmodule

bind serout_fmt serout_fmt_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .bck   (bck_o),
    .wck   (wck_o),
    .dg    (dg_o),
    .dl    (dout_l),
    .dr    (dout_r)
);

// File: tb/test_serout_fmt.sv
module test_serout_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_fast = 1'b0;
    logic [1:0]  len_code = 2'd0;
    logic [24:0] smp_l = '0;
    logic [24:0] smp_r = '0;
    logic        bck_o, wck_o, dg_o, dout_l, dout_r;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serout_fmt i_serout_fmt (
        .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .len_code(len_code),
        .smp_l(smp_l), .smp_r(smp_r), .bck_o(bck_o), .wck_o(wck_o),
        .dg_o(dg_o), .dout_l(dout_l), .dout_r(dout_r)
    );

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int len_of(logic [1:0] code);
        return 24 - 2 * int'(code);
    endfunction
    function automatic int word_of(logic fast);
        return fast ? 24 : 32;
    endfunction
    function automatic int strb_of(logic fast);
        return fast ? 10 : 14;
    endfunction
    function automatic int lsb_of(logic fast, int n);
        if (!fast) return 31;
        return (n == 24) ? 22 : 23;
    endfunction
    // R7, R8: round half up, then clamp to the largest positive value; returned as n raw bits.
    function automatic longint exp_word(logic [24:0] x, int n);
        longint v, r, mx;
        int sh;
        v  = longint'($signed(x));
        sh = 25 - n;
        r  = (v + (64'sd1 <<< (sh - 1))) >>> sh;
        mx = (64'sd1 <<< (n - 1)) - 1;
        if (r > mx) r = mx;
        return r & ((64'sd1 <<< n) - 1);
    endfunction
    function automatic logic [24:0] pick();
        case ($urandom % 8)
            0: return 25'h0FFFFFF;
            1: return 25'h1000000;
            2: return 25'h1FFFFFF;
            3: return 25'h0FFFFC0;
            default: return 25'($urandom);
        endcase
    endfunction

    // Monitor state.
    logic       prev_wck = 1'b0, prev_dg = 1'b0, prev_dl = 1'b0, prev_dr = 1'b0, hi_nobck = 1'b0;
    logic [2:0] prev_cfg = '0;
    int c = 0, wck_cnt = 0, dg_cnt = 0, skip = 3, since = 100, nb = 0, last_c = 0;
    int lat_n = 24, bur_n = 24;
    logic lat_fast = 1'b0, bur_fast = 1'b0;
    longint acc_l = 0, acc_r = 0, lat_l = 0, lat_r = 0, bur_l = 0, bur_r = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            skip = 3; prev_wck = 1'b0; prev_dg = 1'b0; wck_cnt = 0; dg_cnt = 0;
            since = 100; nb = 0; c = 0; hi_nobck = 1'b0;
            prev_cfg = {rate_fast, len_code};
        end else begin
            if ({rate_fast, len_code} != prev_cfg) skip = 3;
            prev_cfg = {rate_fast, len_code};
            if (hi_nobck && skip == 0)
                check(bck_o == 1'b1, "R11 high data not followed by a bit pulse", bck_o, 1);
            hi_nobck = (dout_l || dout_r) && !bck_o;
            if (wck_o && !prev_wck) begin
                if (skip == 0)
                    check(c + 1 == 2 * word_of(rate_fast), "R2 word length in cycles", c + 1, 2 * word_of(rate_fast));
                if (skip > 0) skip--;
                c = 0;
                wck_cnt = 0;
            end else begin
                c++;
            end
            if (wck_o) wck_cnt++;
            if (!wck_o && prev_wck) begin
                if (skip == 0)
                    check(wck_cnt == word_of(rate_fast), "R3 word clock high cycles", wck_cnt, word_of(rate_fast));
                lat_l = exp_word(smp_l, len_of(len_code));
                lat_r = exp_word(smp_r, len_of(len_code));
                lat_n = len_of(len_code);
                lat_fast = rate_fast;
            end
            prev_wck = wck_o;
            if (dg_o && !prev_dg && skip == 0)
                check(c == 2 * (word_of(rate_fast) / 2 + 1), "R4 strobe start cycle", c, 2 * (word_of(rate_fast) / 2 + 1));
            if (dg_o) dg_cnt++;
            if (!dg_o && prev_dg) begin
                if (skip == 0)
                    check(dg_cnt == 2 * strb_of(rate_fast), "R4 strobe high cycles", dg_cnt, 2 * strb_of(rate_fast));
                dg_cnt = 0;
            end
            prev_dg = dg_o;
            if (bck_o) begin
                if (since > 2) begin
                    nb = 0; acc_l = 0; acc_r = 0;
                    bur_l = lat_l; bur_r = lat_r; bur_n = lat_n; bur_fast = lat_fast;
                end
                if (skip == 0)
                    check(dout_l == prev_dl && dout_r == prev_dr, "R5 data stable across bit pulse",
                          {dout_l, dout_r}, {prev_dl, prev_dr});
                acc_l = (acc_l << 1) | longint'(dout_l);
                acc_r = (acc_r << 1) | longint'(dout_r);
                nb++;
                since = 0;
                last_c = c;
            end else begin
                if (since < 100) since++;
                if (since == 2 && nb > 0) begin
                    if (skip == 0) begin
                        check(nb == bur_n, "R1 bit pulses per burst", nb, bur_n);
                        check(acc_l == bur_l, "R7 R8 R9 left word", acc_l, bur_l);
                        check(acc_r == bur_r, "R7 R8 R9 right word", acc_r, bur_r);
                        check(last_c == 2 * lsb_of(bur_fast, bur_n) + 1, "R6 last bit slot",
                              last_c, 2 * lsb_of(bur_fast, bur_n) + 1);
                    end
                    nb = 0;
                end
            end
            prev_dl = dout_l;
            prev_dr = dout_r;
        end
    end

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check({bck_o, wck_o, dg_o, dout_l, dout_r} == 5'b0, "R10 outputs low in reset",
                  {bck_o, wck_o, dg_o, dout_l, dout_r}, 0);
        end
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(wck_o && !bck_o && !dg_o, "R10 word starts on release", {wck_o, bck_o, dg_o}, 3'b100);
    endtask

    task automatic next_word();
        @(posedge wck_o);
        @(negedge clk); #1;
        smp_l = pick();
        smp_r = pick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        for (int cfg = 0; cfg < 8; cfg++) begin
            next_word();
            rate_fast = cfg[2];
            len_code  = cfg[1:0];
            for (int w = 0; w < 8; w++) next_word();
        end
        do_reset();
        rate_fast = 1'b1;
        len_code  = 2'd0;
        for (int w = 0; w < 8; w++) next_word();
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule